// File: doc/BRIEF.md
# Paged Address Translator with Lookaside Buffer

This block turns a logical address from a processor into a physical address. The logical address is split into a page number in its upper bits and a byte offset in its lower bits. The page number selects an entry of a single-level page table held in main memory. The frame number found there, followed by the untouched offset, forms the physical address. A small fully associative lookaside buffer keeps recently used page-to-frame pairs, so most translations need no table access at all.

A request is accepted when `reqValid` and `reqReady` are both high. A buffer hit answers on the next cycle. On a miss the block issues one memory read for the table entry at `tableBase + page`. It answers one cycle after that read returns and stores the pair in the buffer, with slots replaced in round-robin order. A page number at or beyond `tableLen` faults at once and reads nothing. An entry whose valid bit is clear also faults and is not cached. Pulsing `baseWrite` when the table moves empties the buffer. The hit and miss counters let a bench measure how often the extra table read was avoided.

Top module: `page_xlate`

## Requirements
- R1: The physical address is `{frame, offset}`. The offset is the low `OFF_W` bits of the logical address (default 10, a 1 KiB page) and is passed through unchanged. The page number is logical bits `[LA_W-1:OFF_W]`.
- R2: When an accepted request's page is held in the buffer, `respValid` rises on the following cycle with the cached frame. No memory read is made and `hitCount` rises by one.
- R3: When an accepted request misses, `memReqValid` holds with `memReqAddr = tableBase + page` until `memRespValid`. `reqReady` is low during this wait. `respValid` follows exactly one cycle after `memRespValid`. One memory read is made and `missCount` rises by one.
- R4: A table entry is `FRAME_W+1` bits wide. Bit `FRAME_W` is the valid bit and bits `[FRAME_W-1:0]` hold the frame. An entry with the valid bit clear returns `respFault=1` with `respAddr=0` and is not cached, so the same page misses again.
- R5: A page number at or above `tableLen` returns `respFault=1` with `respAddr=0` on the following cycle. No memory read is made and neither counter changes. `tableLen-1` is a legal page.
- R6: After a miss with a valid entry, the same page hits on later requests.
- R7: The buffer holds `TLB_N` entries (default 8) and fills slots in round-robin order starting at slot 0. The `TLB_N+1`-th distinct page evicts the first page; the others stay resident.
- R8: A one-cycle pulse on `baseWrite` invalidates every buffer entry. The next request misses and reads from the new `tableBase`.
- R9: After reset, `reqReady=1`, `respValid=0`, `memReqValid=0` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqAddr | input | LA_W | Logical address |
| reqReady | output | 1 | Block can accept a request |
| respValid | output | 1 | One-cycle result strobe |
| respAddr | output | PA_W | Physical address (zero on fault) |
| respFault | output | 1 | Length violation or invalid entry |
| tableBase | input | MEM_AW | Word address of page table |
| tableLen | input | LA_W-OFF_W+1 | Number of table entries |
| baseWrite | input | 1 | Base-register write strobe; flushes buffer |
| memReqValid | output | 1 | Table read request |
| memReqAddr | output | MEM_AW | Table entry address |
| memRespValid | input | 1 | Table read data present |
| memRespData | input | PA_W-OFF_W+1 | Table entry {valid, frame} |
| hitCount | output | CNT_W | Buffer hits since reset |
| missCount | output | CNT_W | Table reads since reset |

## Verification
Some rules can be checked on every cycle. An accepted request must lead either to a result or to a table read on the next cycle. A page over the length limit must fault at once without a read. The requester must be stalled while a read is outstanding. The result must follow the read data by exactly one cycle and carry the returned frame, or a zero-address fault for an invalid entry. The hit counter may step by at most one per cycle. Other behaviour depends on what the buffer holds, and only the bench's sequences can show it: whether a page hits or misses, round-robin eviction after nine distinct pages, the flush on a base write, and the fact that a faulting entry is never cached.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Strobes from control to datapath, at most one action per cycle
  typedef struct packed {
    logic accept;      // capture request fields
    logic hit;         // answer from buffer
    logic lenFault;    // page over table length
    logic startMiss;   // begin table read
    logic refill;      // valid entry returned: answer and cache
    logic entryFault;  // invalid entry returned
  } xlateCtl_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      lenOk,
  input  logic      tlbHit,
  input  logic      memRespValid,
  input  logic      pteValid,
  output logic      reqReady,
  output logic      memReqValid,
  output xlateCtl_t ctl
);
  typedef enum logic {S_IDLE, S_FETCH} state_t;
  state_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctl         = '0;
    stateD      = stateQ;
    reqReady    = (stateQ == S_IDLE);
    memReqValid = (stateQ == S_FETCH);
    case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          ctl.accept = 1'b1;
          if (!lenOk)      ctl.lenFault = 1'b1;
          else if (tlbHit) ctl.hit = 1'b1;
          else begin
            ctl.startMiss = 1'b1;
            stateD        = S_FETCH;
          end
        end
      end
      default: begin
        if (memRespValid) begin
          if (pteValid) ctl.refill = 1'b1;
          else          ctl.entryFault = 1'b1;
          stateD = S_IDLE;
        end
      end
    endcase
  end
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int LA_W   = 20,
  parameter int PA_W   = 20,
  parameter int OFF_W  = 10,
  parameter int MEM_AW = 16,
  parameter int TLB_N  = 8,
  parameter int CNT_W  = 16,
  localparam int VPN_W   = LA_W - OFF_W,
  localparam int FRAME_W = PA_W - OFF_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [LA_W-1:0]    reqAddr,
  input  logic [MEM_AW-1:0]  tableBase,
  input  logic [VPN_W:0]     tableLen,
  input  logic               baseWrite,
  input  logic [FRAME_W:0]   memRespData,
  input  xlateCtl_t          ctl,
  output logic               lenOk,
  output logic               tlbHit,
  output logic               pteValid,
  output logic [MEM_AW-1:0]  memReqAddr,
  output logic               respValid,
  output logic [PA_W-1:0]    respAddr,
  output logic               respFault,
  output logic [CNT_W-1:0]   hitCount,
  output logic [CNT_W-1:0]   missCount
);
  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [VPN_W-1:0]   reqVpn, heldVpn;
  logic [OFF_W-1:0]   reqOff, heldOff;
  logic [FRAME_W-1:0] pteFrame, hitFrame;
  logic [VPN_W-1:0]   tagQ   [TLB_N];
  logic [FRAME_W-1:0] frameQ [TLB_N];
  logic [TLB_N-1:0]   validQ, matchVec;
  logic [IDX_W-1:0]   ptrQ;

  assign reqVpn   = reqAddr[LA_W-1:OFF_W];
  assign reqOff   = reqAddr[OFF_W-1:0];
  assign pteValid = memRespData[FRAME_W];
  assign pteFrame = memRespData[FRAME_W-1:0];
  assign lenOk    = ({1'b0, reqVpn} < tableLen);
  assign memReqAddr = tableBase + MEM_AW'(heldVpn);

  // Parallel tag compare, one comparator per slot
  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign matchVec[i] = validQ[i] && (tagQ[i] == reqVpn);
  end
  assign tlbHit = |matchVec;

  always_comb begin
    hitFrame = '0;
    for (int i = 0; i < TLB_N; i++)
      if (matchVec[i]) hitFrame = hitFrame | frameQ[i];
  end

  always_ff @(posedge clk) begin
    if (ctl.accept) begin
      heldVpn <= reqVpn;
      heldOff <= reqOff;
    end
  end

  // Slot contents need no reset; only the valid bits do
  always_ff @(posedge clk) begin
    if (ctl.refill && !baseWrite) begin
      tagQ[ptrQ]   <= heldVpn;
      frameQ[ptrQ] <= pteFrame;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      ptrQ   <= '0;
    end else if (baseWrite) begin
      validQ <= '0;
    end else if (ctl.refill) begin
      validQ[ptrQ] <= 1'b1;
      ptrQ <= (ptrQ == IDX_W'(TLB_N - 1)) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respFault <= 1'b0;
      respAddr  <= '0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      respValid <= ctl.hit | ctl.lenFault | ctl.refill | ctl.entryFault;
      respFault <= ctl.lenFault | ctl.entryFault;
      if (ctl.hit)         respAddr <= {hitFrame, reqOff};
      else if (ctl.refill) respAddr <= {pteFrame, heldOff};
      else                 respAddr <= '0;
      if (ctl.hit)       hitCount  <= hitCount + 1'b1;
      if (ctl.startMiss) missCount <= missCount + 1'b1;
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import xlate_pkg::*;
#(
  parameter int LA_W   = 20,
  parameter int PA_W   = 20,
  parameter int OFF_W  = 10,
  parameter int MEM_AW = 16,
  parameter int TLB_N  = 8,
  parameter int CNT_W  = 16
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [LA_W-1:0]         reqAddr,
  output logic                    reqReady,
  output logic                    respValid,
  output logic [PA_W-1:0]         respAddr,
  output logic                    respFault,
  input  logic [MEM_AW-1:0]       tableBase,
  input  logic [LA_W-OFF_W:0]     tableLen,
  input  logic                    baseWrite,
  output logic                    memReqValid,
  output logic [MEM_AW-1:0]       memReqAddr,
  input  logic                    memRespValid,
  input  logic [PA_W-OFF_W:0]     memRespData,
  output logic [CNT_W-1:0]        hitCount,
  output logic [CNT_W-1:0]        missCount
);
  xlateCtl_t ctl;
  logic lenOk, tlbHit, pteValid;

  xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lenOk(lenOk),
    .tlbHit(tlbHit), .memRespValid(memRespValid), .pteValid(pteValid),
    .reqReady(reqReady), .memReqValid(memReqValid), .ctl(ctl)
  );

  xlate_dp #(
    .LA_W(LA_W), .PA_W(PA_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW),
    .TLB_N(TLB_N), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .tableBase(tableBase),
    .tableLen(tableLen), .baseWrite(baseWrite), .memRespData(memRespData),
    .ctl(ctl), .lenOk(lenOk), .tlbHit(tlbHit), .pteValid(pteValid),
    .memReqAddr(memReqAddr), .respValid(respValid), .respAddr(respAddr),
    .respFault(respFault), .hitCount(hitCount), .missCount(missCount)
  );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int LA_W   = 20,
  parameter int PA_W   = 20,
  parameter int OFF_W  = 10,
  parameter int MEM_AW = 16,
  parameter int TLB_N  = 8,
  parameter int CNT_W  = 16
)(
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [LA_W-1:0]     reqAddr,
  input logic                reqReady,
  input logic                respValid,
  input logic [PA_W-1:0]     respAddr,
  input logic                respFault,
  input logic [LA_W-OFF_W:0] tableLen,
  input logic                memReqValid,
  input logic                memRespValid,
  input logic [PA_W-OFF_W:0] memRespData,
  input logic [CNT_W-1:0]    hitCount
);
  localparam int FRAME_W = PA_W - OFF_W;

  assert_accept_progress_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (respValid || memReqValid));

  assert_len_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && ({1'b0, reqAddr[LA_W-1:OFF_W]} >= tableLen))
      |=> (respValid && respFault && !memReqValid));

  assert_fetch_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  assert_miss_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRespValid) |=> respValid);

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> (respValid && respAddr == '0));

  assert_entry_fault_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRespValid && !memRespData[FRAME_W]) |=> respFault);

  assert_refill_frame_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRespValid && memRespData[FRAME_W])
      |=> (!respFault && respAddr[PA_W-1:OFF_W] == $past(memRespData[FRAME_W-1:0])));

  assert_hit_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount == $past(hitCount)) || (hitCount == $past(hitCount) + CNT_W'(1)));
endmodule

bind page_xlate xlate_chk #(
  .LA_W(LA_W), .PA_W(PA_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW),
  .TLB_N(TLB_N), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_page_xlate.sv
`timescale 1ns/1ps
module sim_page_xlate;
  localparam int LA_W = 20, PA_W = 20, OFF_W = 10, MEM_AW = 16, TLB_N = 8, CNT_W = 16;
  localparam int VPN_W = LA_W - OFF_W, FRAME_W = PA_W - OFF_W;
  localparam int MEM_DELAY = 3;
  localparam int MISS_LAT = MEM_DELAY + 3;
  // kind: 0 hit, 1 miss, 2 length fault, 3 invalid entry
  localparam int NVEC = 8;
  localparam logic [LA_W+1:0] VEC [NVEC] = '{
    {2'd1, 10'd5,  10'h03A},
    {2'd0, 10'd5,  10'h000},
    {2'd0, 10'd5,  10'h3FF},
    {2'd2, 10'd64, 10'h011},
    {2'd1, 10'd63, 10'h155},
    {2'd0, 10'd63, 10'h2AA},
    {2'd3, 10'd13, 10'h001},
    {2'd3, 10'd13, 10'h002}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, baseWrite = 0;
  logic [LA_W-1:0] reqAddr = '0;
  logic [MEM_AW-1:0] tableBase = 16'h0100;
  logic [VPN_W:0] tableLen = 11'd64;
  logic reqReady, respValid, respFault, memReqValid;
  logic [PA_W-1:0] respAddr;
  logic [MEM_AW-1:0] memReqAddr, lastAddr;
  logic memRespValid;
  logic [FRAME_W:0] memRespData;
  logic [CNT_W-1:0] hitCount, missCount;
  int cnt, reads;
  int checks = 0, fails = 0;
  int expHits = 0, expMisses = 0;

  always #4 clk = ~clk;

  page_xlate u0 (.*);

  function automatic logic [FRAME_W:0] pteOf(logic [MEM_AW-1:0] a);
    logic [MEM_AW-1:0] f;
    f = a * 5 + 9;
    return {(a[3:0] != 4'd13), f[FRAME_W-1:0]};
  endfunction

  // Table memory with fixed read delay
  always @(posedge clk) begin
    if (!rstN) begin
      cnt <= 0; reads <= 0; memRespValid <= 0; memRespData <= '0; lastAddr <= '0;
    end else begin
      memRespValid <= 0;
      if (cnt == 1) begin
        memRespValid <= 1;
        memRespData  <= pteOf(lastAddr);
        cnt   <= 0;
        reads <= reads + 1;
      end else if (cnt != 0) cnt <= cnt - 1;
      else if (memReqValid && !memRespValid) begin
        cnt <= MEM_DELAY;
        lastAddr <= memReqAddr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [LA_W-1:0] a, output logic [PA_W-1:0] pa,
                       output logic flt, output int lat, output bit stalled);
    @(negedge clk);
    reqValid = 1; reqAddr = a;
    @(negedge clk);
    reqValid = 0; lat = 1; stalled = 1;
    while (!respValid && lat < 50) begin
      if (reqReady) stalled = 0;
      @(negedge clk);
      lat++;
    end
    pa = respAddr; flt = respFault;
  endtask

  // Full translation with expectations by kind
  task automatic run(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                     input int kind, input string req);
    logic [PA_W-1:0] pa; logic flt; int lat; bit stalled; int r0;
    logic [FRAME_W:0] e;
    r0 = reads;
    e = pteOf(tableBase + MEM_AW'(vpn));
    xlate({vpn, off}, pa, flt, lat, stalled);
    case (kind)
      0: begin
        expHits++;
        check(lat == 1, req, "hit latency", lat, 1);
        check(!flt && pa == {e[FRAME_W-1:0], off}, req, "hit address", pa, {e[FRAME_W-1:0], off});
        check(reads == r0, req, "hit reads", reads - r0, 0);
      end
      1: begin
        expMisses++;
        check(lat == MISS_LAT && stalled, req, "miss latency/stall", lat, MISS_LAT);
        check(!flt && pa == {e[FRAME_W-1:0], off}, req, "miss address", pa, {e[FRAME_W-1:0], off});
        check(reads == r0 + 1, req, "miss reads", reads - r0, 1);
        check(lastAddr == tableBase + MEM_AW'(vpn), req, "table addr", lastAddr, tableBase + MEM_AW'(vpn));
      end
      2: begin
        check(lat == 1 && flt && pa == '0, req, "length fault", {flt, pa}, {1'b1, 20'h0});
        check(reads == r0, req, "length fault reads", reads - r0, 0);
      end
      default: begin
        expMisses++;
        check(lat == MISS_LAT && flt && pa == '0, req, "entry fault", {flt, pa}, {1'b1, 20'h0});
        check(reads == r0 + 1, req, "entry fault reads", reads - r0, 1);
      end
    endcase
    check(hitCount == CNT_W'(expHits), req, "hitCount", hitCount, expHits);
    check(missCount == CNT_W'(expMisses), req, "missCount", missCount, expMisses);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    // R9 reset state
    check(reqReady && !respValid && !memReqValid, "R9", "reset handshake",
          {reqReady, respValid, memReqValid}, 3'b100);
    check(hitCount == 0 && missCount == 0, "R9", "reset counters", {hitCount, missCount}, 0);

    // Vector table: R1 offsets, R2 hits, R3 misses, R4 invalid entry, R5 length, R6 refill
    for (int i = 0; i < NVEC; i++) begin
      int k;
      k = int'(VEC[i][LA_W+1:LA_W]);
      run(VEC[i][LA_W-1:OFF_W], VEC[i][OFF_W-1:0], k,
          (k == 0) ? "R2/R6" : (k == 1) ? "R3/R1" : (k == 2) ? "R5" : "R4");
    end

    // R7 round-robin: nine distinct pages, first evicted
    for (int v = 20; v <= 28; v++) run(VPN_W'(v), 10'h00F, 1, "R7");
    run(10'd28, 10'h123, 0, "R7");
    run(10'd22, 10'h321, 0, "R7");
    run(10'd20, 10'h0F0, 1, "R7");

    // R8 flush on base write, new base used
    @(negedge clk);
    tableBase = 16'h0200; baseWrite = 1;
    @(negedge clk);
    baseWrite = 0;
    run(10'd22, 10'h3C3, 1, "R8");
    run(10'd22, 10'h044, 0, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule